// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host end of a serialized interrupt bus. All agents share one open-drain line. Every agent drives the line and samples it on the rising edge of the bus clock. The host opens each bus cycle with a start frame and then walks a fixed run of interrupt/data frames, one frame per interrupt line. It latches the level seen in each frame into a parallel interrupt vector.

The host closes the cycle with a stop frame, and the width of that frame tells every agent which mode the next cycle uses. A two-clock stop selects quiet mode. The host then leaves the line released and waits for a peripheral to open the next cycle, and it joins that start so that the whole start frame keeps its configured width. A three-clock stop selects continuous mode, in which the host alone opens the next cycle as soon as the idle gap has passed.

After reset the host runs a first cycle on its own to collect the default interrupt levels. An ordering output stays high while a cycle is in flight, so that end-of-interrupt and in-service reads at the interrupt controller can be held until the updates in flight have landed.

Top module: `sirq_host`

## Requirements
- R1: While rst_n is low the line is not driven (sirq_oe = 0), irq_vec is all zeros and eoi_hold is 0.
- R2: On the first clock edge after reset is released, the host begins a start frame without waiting for any agent, so sirq_oe is high in the very next clock.
- R3: A start frame holds the line low for 4, 6 or 8 clocks. start_sel selects the width (00 gives 4, 01 gives 6, 10 and 11 give 8), and its value is taken at the edge that enters the start frame. One released turnaround clock follows the start frame.
- R4: NUM_FRAMES data frames follow, each three clocks long (sample, recovery, turnaround). irq_vec[i] is 1 exactly when the line was low in the sample clock of frame i (the line is active-low). The bit updates at the edge that ends that clock and holds at all other times.
- R5: The host never drives the line during data frames.
- R6: The stop frame starts right after the last frame's turnaround. It is 2 clocks low if quiet_req is 1 at the edge ending that turnaround, and 3 clocks low if quiet_req is 0.
- R7: After every stop frame the line stays released for at least two clocks. After a 3-clock stop the host starts its next start frame after exactly two released clocks.
- R8: After a 2-clock stop the host waits with the line released. If it samples the line low, it drives the line for the remaining width-1 clocks, so the low time of the start frame equals the configured width, and it then runs the frames.
- R9: While waiting in quiet mode, quiet_req = 0 makes the host open its own start frame in the next clock. If a peripheral start is sampled in the same clock, the peripheral start wins and the host drives only width-1 clocks.
- R10: A low on the line during the two-clock gap after a quiet stop is ignored: no cycle starts and eoi_hold stays 0.
- R11: eoi_hold is 1 from the first start clock through the last stop clock and 0 otherwise, and the host drives only while eoi_hold is 1.
- R12: A continuous-mode cycle repeats every width + 1 + 3*NUM_FRAMES + 3 + 2 clocks. With 17 frames and an 8-clock start this is 65 clocks, no more than 96.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all driving and sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sirq_in | input | 1 | Level of the shared line as seen at the pad |
| sirq_out | output | 1 | Value the host drives, always 0 (open drain) |
| sirq_oe | output | 1 | High when the host pulls the line low |
| start_sel | input | 2 | Start frame width select |
| quiet_req | input | 1 | 1 requests quiet mode for the next cycle, 0 continuous |
| irq_vec | output | NUM_FRAMES | Latched interrupt levels, 1 = asserted |
| eoi_hold | output | 1 | High while a bus cycle is in flight |

## Verification
Two of the block's functions can fall in the same clock while the host waits in quiet mode. One is the detection of a start frame opened by a peripheral. The other is the host's own wake-up when quiet_req drops. The bench provokes the collision by pulling the line low and clearing quiet_req at the same clock. It judges the result by the measured low width of the start frame, which must equal the configured width and not exceed it by one. Besides this, the bench pulses the line inside the post-stop gap to show that such a pulse is ignored, and it resets the block in the middle of a run.

// File: rtl/sirq_host_pkg.sv
// Package: shared types and constants for the serial interrupt host.
// Assumes a bus clock shared by all agents; widths here bound the
// start/stop/gap counter.
package sirq_host_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_START,
        ST_TURN,
        ST_FRAME,
        ST_STOP,
        ST_GAP,
        ST_QIDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } frame_phase_e;

    localparam int unsigned CNT_W           = 4;
    localparam int unsigned STOP_QUIET_CLKS = 2;
    localparam int unsigned STOP_CONT_CLKS  = 3;
    localparam int unsigned GAP_CLKS        = 2;

    // Map the width select code to the start frame low time in clocks.
    function automatic logic [CNT_W-1:0] start_clks(input logic [1:0] sel);
        case (sel)
            2'b00:   return CNT_W'(4);
            2'b01:   return CNT_W'(6);
            default: return CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/sirq_host_startdet.sv
// Module: sirq_host_startdet
// Decides how a quiet-mode wait ends. A low level on the line seen while
// waiting marks a start frame opened by a peripheral; otherwise a drop of
// quiet_req wakes the host to open its own start. Assumes the line input
// is already synchronous to clk. Peripheral start has priority.
module sirq_host_startdet (
    input  logic in_qidle,
    input  logic line_in,
    input  logic quiet_req,
    output logic periph_start,
    output logic host_wake
);

    // Combine wait state, line level and mode request into the two exits.
    always_comb begin
        periph_start = in_qidle && !line_in;
        host_wake    = in_qidle && line_in && !quiet_req;
    end

endmodule

// File: rtl/sirq_host_seq.sv
// Module: sirq_host_seq
// Frame sequencer of the host: boot, start frame, turnaround, NUM_FRAMES
// three-clock data frames, stop frame whose width carries the next mode,
// idle gap, then either an immediate restart (continuous) or a wait for
// a start (quiet). Assumes periph_start/host_wake are only raised in the
// quiet wait state.
module sirq_host_seq
    import sirq_host_pkg::*;
#(
    parameter int NUM_FRAMES = 17,
    localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       start_sel,
    input  logic             quiet_req,
    input  logic             periph_start,
    input  logic             host_wake,
    output logic             drive_low,
    output logic             cycle_busy,
    output logic             in_qidle,
    output logic             sample_en,
    output logic [FRM_W-1:0] frame_idx
);

    localparam logic [FRM_W-1:0] LAST_FRAME = FRM_W'(NUM_FRAMES - 1);

    seq_state_e       state_q, state_n;
    frame_phase_e     phase_q, phase_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] len_q, len_n;
    logic [FRM_W-1:0] frame_q, frame_n;
    logic             quiet_q, quiet_n;
    logic [CNT_W-1:0] stop_last;

    // Last count value of the stop frame for the latched mode.
    always_comb begin
        stop_last = quiet_q ? CNT_W'(STOP_QUIET_CLKS - 1) : CNT_W'(STOP_CONT_CLKS - 1);
    end

    // Next-state logic of the frame sequencer.
    always_comb begin
        state_n = state_q;
        phase_n = phase_q;
        cnt_n   = cnt_q;
        len_n   = len_q;
        frame_n = frame_q;
        quiet_n = quiet_q;
        case (state_q)
            ST_BOOT: begin
                state_n = ST_START;
                cnt_n   = '0;
                len_n   = start_clks(start_sel);
            end
            ST_START: begin
                if (cnt_q == len_q - CNT_W'(1)) begin
                    state_n = ST_TURN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_TURN: begin
                state_n = ST_FRAME;
                frame_n = '0;
                phase_n = PH_SAMPLE;
            end
            ST_FRAME: begin
                case (phase_q)
                    PH_SAMPLE:  phase_n = PH_RECOVER;
                    PH_RECOVER: phase_n = PH_TURN;
                    default: begin
                        phase_n = PH_SAMPLE;
                        if (frame_q == LAST_FRAME) begin
                            state_n = ST_STOP;
                            cnt_n   = '0;
                            quiet_n = quiet_req;
                        end else begin
                            frame_n = frame_q + FRM_W'(1);
                        end
                    end
                endcase
            end
            ST_STOP: begin
                if (cnt_q == stop_last) begin
                    state_n = ST_GAP;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (cnt_q == CNT_W'(GAP_CLKS - 1)) begin
                    cnt_n = '0;
                    if (quiet_q) begin
                        state_n = ST_QIDLE;
                    end else begin
                        state_n = ST_START;
                        len_n   = start_clks(start_sel);
                    end
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_QIDLE: begin
                if (periph_start) begin
                    state_n = ST_START;
                    cnt_n   = CNT_W'(1);
                    len_n   = start_clks(start_sel);
                end else if (host_wake) begin
                    state_n = ST_START;
                    cnt_n   = '0;
                    len_n   = start_clks(start_sel);
                end
            end
            default: state_n = ST_BOOT;
        endcase
    end

    // Sequencer state registers with synchronous reset into the boot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            phase_q <= PH_SAMPLE;
            cnt_q   <= '0;
            len_q   <= start_clks(2'b00);
            frame_q <= '0;
            quiet_q <= 1'b0;
        end else begin
            state_q <= state_n;
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
            len_q   <= len_n;
            frame_q <= frame_n;
            quiet_q <= quiet_n;
        end
    end

    // Decode the registered state into the control strobes.
    always_comb begin
        drive_low  = (state_q == ST_START) || (state_q == ST_STOP);
        cycle_busy = (state_q == ST_START) || (state_q == ST_TURN) ||
                     (state_q == ST_FRAME) || (state_q == ST_STOP);
        in_qidle   = (state_q == ST_QIDLE);
        sample_en  = (state_q == ST_FRAME) && (phase_q == PH_SAMPLE);
        frame_idx  = frame_q;
    end

endmodule

// File: rtl/sirq_host_capture.sv
// Module: sirq_host_capture
// Holds one latched interrupt level per frame. In the sample clock of
// frame i, bit i takes the inverted line level (line low = asserted).
// Assumes frame_idx is below NUM_FRAMES whenever sample_en is high.
module sirq_host_capture #(
    parameter int NUM_FRAMES = 17,
    localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic [FRM_W-1:0]      frame_idx,
    input  logic                  line_in,
    output logic [NUM_FRAMES-1:0] irq_vec
);

    logic [NUM_FRAMES-1:0] hit;
    logic [NUM_FRAMES-1:0] vec_q;

    // One decode per frame selects the bit written in this clock.
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_hit
        assign hit[i] = sample_en && (frame_idx == FRM_W'(i));
    end

    // Update the selected bit, keep all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= (vec_q & ~hit) | (hit & {NUM_FRAMES{~line_in}});
        end
    end

    assign irq_vec = vec_q;

endmodule

// File: rtl/sirq_host.sv
// Module: sirq_host
// Top of the serial interrupt host: ties the sequencer, the quiet-mode
// start detector and the per-frame capture register to the shared line.
// Assumes an external open-drain pad: the line is low when sirq_oe is high.
module sirq_host #(
    parameter int NUM_FRAMES = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sirq_in,
    output logic                  sirq_out,
    output logic                  sirq_oe,
    input  logic [1:0]            start_sel,
    input  logic                  quiet_req,
    output logic [NUM_FRAMES-1:0] irq_vec,
    output logic                  eoi_hold
);

    localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    logic             periph_start;
    logic             host_wake;
    logic             drive_low;
    logic             cycle_busy;
    logic             in_qidle;
    logic             sample_en;
    logic [FRM_W-1:0] frame_idx;

    sirq_host_startdet u_startdet (
        .in_qidle     (in_qidle),
        .line_in      (sirq_in),
        .quiet_req    (quiet_req),
        .periph_start (periph_start),
        .host_wake    (host_wake)
    );

    sirq_host_seq #(.NUM_FRAMES(NUM_FRAMES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_sel    (start_sel),
        .quiet_req    (quiet_req),
        .periph_start (periph_start),
        .host_wake    (host_wake),
        .drive_low    (drive_low),
        .cycle_busy   (cycle_busy),
        .in_qidle     (in_qidle),
        .sample_en    (sample_en),
        .frame_idx    (frame_idx)
    );

    sirq_host_capture #(.NUM_FRAMES(NUM_FRAMES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .frame_idx (frame_idx),
        .line_in   (sirq_in),
        .irq_vec   (irq_vec)
    );

    // Open-drain drive: value fixed low, enable from the sequencer.
    always_comb begin
        sirq_out = 1'b0;
        sirq_oe  = drive_low;
        eoi_hold = cycle_busy;
    end

endmodule

// File: rtl/sirq_host_chk.sv
// Module: sirq_host_chk
// Protocol checker bound to sirq_host; observes only the top ports.
module sirq_host_chk #(
    parameter int NUM_FRAMES = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sirq_oe,
    input logic [NUM_FRAMES-1:0] irq_vec,
    input logic                  eoi_hold
);

    // R11: the host drives only inside a cycle in flight.
    assert_drive_in_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_hold |-> !sirq_oe);

    // R3 and R6: every host low pulse lasts at least two clocks.
    assert_pulse_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sirq_oe) |=> sirq_oe);

    // R7: after a cycle ends the line stays released for another clock.
    assert_gap_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoi_hold) |=> (!eoi_hold && !sirq_oe));

    // R4: the vector is frozen while no cycle is in flight.
    assert_vec_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_hold |=> $stable(irq_vec));

    // R4: at most one frame bit changes per clock.
    assert_one_bit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_vec ^ $past(irq_vec)) <= 1);

endmodule

bind sirq_host sirq_host_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sirq_oe  (sirq_oe),
    .irq_vec  (irq_vec),
    .eoi_hold (eoi_hold)
);

// File: tb/sirq_host_tb.sv
`timescale 1ns/1ps
module sirq_host_tb;

    localparam int N  = 17;
    localparam int NV = 6;
    // {start_sel for the following start, frame pattern (1 = pull low)}
    localparam logic [18:0] VEC [NV] = '{
        {2'b01, 17'h00000},
        {2'b10, 17'h1FFFF},
        {2'b00, 17'h0AAAA},
        {2'b11, 17'h15555},
        {2'b10, 17'h00001},
        {2'b10, 17'h10000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          per_drive = 1'b0;
    logic          quiet_req = 1'b0;
    logic [1:0]    start_sel = 2'b00;
    logic          sirq_line;
    logic          sirq_out;
    logic          sirq_oe;
    logic [N-1:0]  irq_vec;
    logic          eoi_hold;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    assign sirq_line = ~((sirq_oe & ~sirq_out) | per_drive);

    always #2.5 clk = ~clk;

    sirq_host #(.NUM_FRAMES(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sirq_in   (sirq_line),
        .sirq_out  (sirq_out),
        .sirq_oe   (sirq_oe),
        .start_sel (start_sel),
        .quiet_req (quiet_req),
        .irq_vec   (irq_vec),
        .eoi_hold  (eoi_hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 4 : (sel == 2'b01) ? 6 : 8;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called at the negedge of a clock where the host already drives start.
    task automatic do_cycle(input int exp_len, input int pre, input bit quiet,
                            input logic [N-1:0] pat, input bit gap_pulse,
                            output int period);
        int low = pre;
        int total = pre;
        int stop = 0;
        int idle = 0;
        while (sirq_oe === 1'b1 && low < 20) begin
            check("R11 hold during start", eoi_hold, 1);
            low++; total++;
            @(negedge clk);
        end
        check("R3 start low width", low, exp_len);
        check("R3 turnaround released", sirq_oe, 0);
        total++;
        @(negedge clk);
        for (int f = 0; f < N; f++) begin
            per_drive = pat[f];
            check("R5 no drive in frame", sirq_oe, 0);
            total++;
            @(negedge clk);
            per_drive = 1'b0;
            total++;
            @(negedge clk);
            check("R11 hold in frame", eoi_hold, 1);
            total++;
            @(negedge clk);
        end
        check("R4 captured vector", int'(irq_vec), int'(pat));
        while (sirq_oe === 1'b1 && stop < 10) begin
            stop++; total++;
            @(negedge clk);
        end
        check("R6 stop width", stop, quiet ? 2 : 3);
        if (!quiet) begin
            while (sirq_oe === 1'b0 && idle < 10) begin
                check("R11 hold low in gap", eoi_hold, 0);
                idle++; total++;
                @(negedge clk);
            end
            check("R7 continuous gap", idle, 2);
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (gap_pulse && k == 0) per_drive = 1'b1;
                if (k == 1) per_drive = 1'b0;
                check("R10 quiet wait no drive", sirq_oe, 0);
                check("R10 quiet wait hold", eoi_hold, 0);
                @(negedge clk);
            end
        end
        period = total;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int period;
        int exp_len;
        repeat (3) @(negedge clk);
        check("R1 reset oe", sirq_oe, 0);
        check("R1 reset vec", int'(irq_vec), 0);
        check("R1 reset hold", eoi_hold, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 initial start", sirq_oe, 1);
        exp_len = 4;

        // Table walk: continuous cycles with various widths and patterns.
        for (int i = 0; i < NV; i++) begin
            start_sel = VEC[i][18:17];
            quiet_req = 1'b0;
            do_cycle(exp_len, 0, 1'b0, VEC[i][16:0], 1'b0, period);
            check("R12 cycle period", period, exp_len + 1 + 3 * N + 3 + 2);
            if (exp_len == 8) check("R12 within 96", int'(period <= 96), 1);
            exp_len = len_of(VEC[i][18:17]);
        end

        // Quiet stop, with a pulse in the gap that must be ignored (R10).
        quiet_req = 1'b1;
        start_sel = 2'b01;
        do_cycle(exp_len, 0, 1'b1, 17'h0F0F0, 1'b1, period);

        // Peripheral opens the start; host joins for width-1 clocks (R8).
        per_drive = 1'b1;
        @(negedge clk);
        per_drive = 1'b0;
        check("R8 host joins peripheral start", sirq_oe, 1);
        do_cycle(6, 1, 1'b1, 17'h13579, 1'b0, period);

        // Dropping quiet_req wakes the host on its own (R9).
        start_sel = 2'b00;
        quiet_req = 1'b0;
        @(negedge clk);
        check("R9 host wake start", sirq_oe, 1);
        quiet_req = 1'b1;
        do_cycle(4, 0, 1'b1, 17'h00F00, 1'b0, period);

        // Collision: peripheral start and wake in the same clock (R9).
        start_sel = 2'b11;
        per_drive = 1'b1;
        quiet_req = 1'b0;
        @(negedge clk);
        per_drive = 1'b0;
        check("R9 collision host drives", sirq_oe, 1);
        do_cycle(8, 1, 1'b0, 17'h1E00F, 1'b0, period);

        // Reset in the middle of a run clears everything (R1, R2).
        start_sel = 2'b00;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-run reset vec", int'(irq_vec), 0);
        check("R1 mid-run reset oe", sirq_oe, 0);
        check("R1 mid-run reset hold", eoi_hold, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 restart after reset", sirq_oe, 1);
        do_cycle(4, 0, 1'b0, 17'h1FFFF, 1'b0, period);
        check("R12 period after reset", period, 4 + 1 + 3 * N + 3 + 2);

        finish_run();
    end

endmodule